// File: doc/BRIEF.md
# Windowed Edge Timestamp Capture

This block keeps a wide cycle counter that runs without pause from reset and takes a snapshot of it when a rising edge shows up on a serial bus line. Several nodes on a shared bus can then compare timestamps of the same frame edge and work out their relative clock offset. The snapshot is taken only while a capture window is open. Software opens the window with a one-cycle arm pulse just before the frame edge it wants to mark, so other transitions on the line leave no trace.

The counter is built from equal cascaded segments. The carry into each segment is formed from the segments below it, and every segment is registered on the same clock edge. The full value is copied into the timestamp register in one cycle, so a carry between segments never produces a mixed value. The bus line passes through a synchronizer whose latency is fixed and the same on every node, so it cancels out when nodes compare timestamps. A held timestamp stays frozen until the host reads it. A read clears the valid flag and closes the window. An edge that arrives while an unread timestamp is waiting sets a sticky overrun flag, and the next arm pulse clears it.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset `stamp_o` is 0, `stamp_vld_o` is 0, `overrun_o` is 0 and the capture window is closed.
- R2: The counter loads `COUNT_INIT` during reset and then advances by exactly one on every clock cycle. It never pauses, so two timestamps differ by the number of cycles between their edges.
- R3: Let C be the count value held while `bus_line_i` first goes high between two clock edges. The captured timestamp is C + `SYNC_STAGES`, taken modulo 2^(`SEG_W`*`SEG_N`).
- R4: A timestamp taken while a carry crosses a segment boundary, including the full wrap from all ones to zero, holds the exact count value with no segment torn.
- R5: A rising edge that occurs while the window is closed leaves `stamp_o` and `stamp_vld_o` unchanged.
- R6: A capture sets `stamp_vld_o`. While `stamp_vld_o` is 1, `stamp_o` does not change, whatever edges arrive.
- R7: A one-cycle `rd_i` pulse clears `stamp_vld_o` and closes the window on the next clock edge. `rd_i` takes priority over `arm_i` in the same cycle.
- R8: A rising edge seen while the window is open and `stamp_vld_o` is 1 sets `overrun_o`. `overrun_o` stays 1 across reads until an `arm_i` pulse clears it.
- R9: Only low-to-high transitions of `bus_line_i` cause a capture. A high-to-low transition inside an open window captures nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counter clock; one count per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_line_i | input | 1 | Asynchronous serial bus line to timestamp |
| arm_i | input | 1 | One-cycle pulse that opens the window and clears overrun |
| rd_i | input | 1 | One-cycle read strobe; clears valid and closes the window |
| stamp_o | output | SEG_W*SEG_N | Held timestamp |
| stamp_vld_o | output | 1 | A timestamp is held and has not been read |
| overrun_o | output | 1 | Sticky flag: an edge arrived while a timestamp was unread |

## Verification
The bench builds the block with the default 16-bit by 2 segment split, two synchronizer stages and `COUNT_INIT` set to 32'hFFFF_FFE0. With that starting value the full 32-bit wrap, where both segments roll over in one cycle, comes about thirty cycles after reset. A capture can therefore be placed exactly on the value zero. The bench then lets the counter run into the carry from the low segment into the high one near 0x0001_0000 and captures there as well. Both segment-boundary cases are checked against a count kept in the bench and the fixed two-cycle synchronizer offset.

// File: rtl/esc_pkg.sv
package esc_pkg;
   // Window state of the capture controller
   typedef enum logic {
      WIN_SHUT = 1'b0,
      WIN_OPEN = 1'b1
   } esc_win_e;

   // Default split of the counter
   localparam int ESC_SEG_W_DFLT  = 16;
   localparam int ESC_SEG_N_DFLT  = 2;
   localparam int ESC_SYNC_DFLT   = 2;
endpackage

// File: rtl/esc_sync_edge.sv
module esc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("esc_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // R9: a detected edge is a single-cycle pulse
   a_r9_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/esc_seg_counter.sv
module esc_seg_counter #(
   parameter int SEG_W = 16,
   parameter int SEG_N = 2,
   localparam int CNT_W = SEG_W * SEG_N,
   parameter logic [CNT_W-1:0] INIT = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (SEG_W < 1 || SEG_N < 1) begin : g_bad_split
         $error("esc_seg_counter: SEG_W and SEG_N must be positive");
      end
   endgenerate

   logic [SEG_N:0]   carry;
   logic [SEG_W-1:0] seg_q [SEG_N];

   assign carry[0] = 1'b1;

   generate
      for (genvar gi = 0; gi < SEG_N; gi++) begin : g_seg
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               seg_q[gi] <= INIT[gi*SEG_W +: SEG_W];
            end else if (carry[gi]) begin
               seg_q[gi] <= seg_q[gi] + 1'b1;
            end
         end
         assign carry[gi+1] = carry[gi] & (&seg_q[gi]);
         assign count_o[gi*SEG_W +: SEG_W] = seg_q[gi];
      end
   endgenerate

   // R2: the assembled count advances by one every cycle
   a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> count_o == $past(count_o) + CNT_W'(1));
endmodule

// File: rtl/esc_capture_ctl.sv
module esc_capture_ctl
   import esc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   input  logic             arm_i,
   input  logic             rd_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] stamp_o,
   output logic             vld_o,
   output logic             ovr_o
);
   esc_win_e         win_q;
   logic [CNT_W-1:0] stamp_q;
   logic             vld_q;
   logic             ovr_q;
   logic             take;
   logic             clash;

   assign take  = rise_i && (win_q == WIN_OPEN) && !vld_q && !rd_i;
   assign clash = rise_i && (win_q == WIN_OPEN) && vld_q && !rd_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         win_q   <= WIN_SHUT;
         stamp_q <= '0;
         vld_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (rd_i) begin
            vld_q <= 1'b0;
            win_q <= WIN_SHUT;
         end else begin
            if (arm_i) win_q <= WIN_OPEN;
            if (take) begin
               stamp_q <= count_i;
               vld_q   <= 1'b1;
            end
         end
         if (arm_i)      ovr_q <= 1'b0;
         else if (clash) ovr_q <= 1'b1;
      end
   end

   assign stamp_o = stamp_q;
   assign vld_o   = vld_q;
   assign ovr_o   = ovr_q;

   // R6: held value frozen while valid and not being read
   a_r6_stamp_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q && !rd_i) |=> $stable(stamp_q));
   // R7: read clears valid and shuts the window
   a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i |=> (!vld_q && win_q == WIN_SHUT));
   // R5: no capture can start while the window is shut
   a_r5_shut_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_q == WIN_SHUT) |=> !$rose(vld_q));
   // R8: overrun is sticky until an arm pulse
   a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_q && !arm_i) |=> ovr_q);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
   parameter int SEG_W       = esc_pkg::ESC_SEG_W_DFLT,
   parameter int SEG_N       = esc_pkg::ESC_SEG_N_DFLT,
   parameter int SYNC_STAGES = esc_pkg::ESC_SYNC_DFLT,
   parameter logic [SEG_W*SEG_N-1:0] COUNT_INIT = '0
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   bus_line_i,
   input  logic                   arm_i,
   input  logic                   rd_i,
   output logic [SEG_W*SEG_N-1:0] stamp_o,
   output logic                   stamp_vld_o,
   output logic                   overrun_o
);
   localparam int CNT_W = SEG_W * SEG_N;

   logic             rise;
   logic [CNT_W-1:0] count;

   esc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (bus_line_i),
      .rise_o  (rise)
   );

   esc_seg_counter #(.SEG_W(SEG_W), .SEG_N(SEG_N), .INIT(COUNT_INIT)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .count_o (count)
   );

   esc_capture_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise),
      .arm_i   (arm_i),
      .rd_i    (rd_i),
      .count_i (count),
      .stamp_o (stamp_o),
      .vld_o   (stamp_vld_o),
      .ovr_o   (overrun_o)
   );
endmodule

// File: tb/edge_stamp_capture_tb_top.sv
`timescale 1ns/1ps
module edge_stamp_capture_tb_top;
   localparam int          LAT  = 2;
   localparam logic [31:0] INIT = 32'hFFFF_FFE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus = 1'b0;
   logic        arm = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] stamp;
   logic        vld;
   logic        ovr;
   logic [31:0] ref_cnt;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) ref_cnt <= !rst_n ? INIT : ref_cnt + 32'd1;

   edge_stamp_capture #(.SEG_W(16), .SEG_N(2), .SYNC_STAGES(LAT), .COUNT_INIT(INIT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_line_i(bus), .arm_i(arm), .rd_i(rd),
      .stamp_o(stamp), .stamp_vld_o(vld), .overrun_o(ovr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic pulse_arm();
      arm = 1'b1; @(negedge clk); arm = 1'b0;
   endtask

   task automatic pulse_rd();
      rd = 1'b1; @(negedge clk); rd = 1'b0;
   endtask

   task automatic raise(output logic [31:0] exp);
      exp = ref_cnt + LAT;
      bus = 1'b1;
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic lower();
      bus = 1'b0;
      repeat (LAT + 2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 stamp", stamp, 32'h0);
      chk("R1 valid", {31'h0, vld}, 32'h0);
      chk("R1 overrun", {31'h0, ovr}, 32'h0);
   endtask

   task automatic t_wrap();
      logic [31:0] e;
      pulse_arm();
      while (ref_cnt != 32'hFFFF_FFFE) @(negedge clk);
      raise(e);
      chk("R4 wrap stamp", stamp, 32'h0000_0000);
      chk("R3 wrap stamp model", stamp, e);
      chk("R6 valid set", {31'h0, vld}, 32'h1);
      pulse_rd();
      chk("R7 valid cleared", {31'h0, vld}, 32'h0);
      lower();
   endtask

   task automatic t_closed();
      logic [31:0] e;
      raise(e);
      repeat (2) @(negedge clk);
      chk("R5 no valid", {31'h0, vld}, 32'h0);
      chk("R5 stamp held", stamp, 32'h0);
      lower();
   endtask

   task automatic t_overrun();
      logic [31:0] e1, e2;
      pulse_arm();
      raise(e1);
      chk("R3 first stamp", stamp, e1);
      lower();
      raise(e2);
      chk("R6 stamp frozen", stamp, e1);
      chk("R8 overrun set", {31'h0, ovr}, 32'h1);
      lower();
      pulse_rd();
      chk("R8 overrun sticky on read", {31'h0, ovr}, 32'h1);
      pulse_arm();
      chk("R8 overrun cleared by arm", {31'h0, ovr}, 32'h0);
      pulse_rd();
   endtask

   task automatic t_falling();
      logic [31:0] e;
      raise(e);
      pulse_arm();
      lower();
      chk("R9 falling ignored", {31'h0, vld}, 32'h0);
      raise(e);
      chk("R3 capture after fall", stamp, e);
      pulse_rd();
      lower();
   endtask

   task automatic t_interval();
      logic [31:0] a, b, da, db;
      pulse_arm();
      da = ref_cnt;
      raise(a);
      a = stamp;
      pulse_rd();
      lower();
      pulse_arm();
      repeat (37) @(negedge clk);
      db = ref_cnt;
      raise(b);
      chk("R2 interval", stamp - a, db - da);
      pulse_rd();
      lower();
   endtask

   task automatic t_read_priority();
      logic [31:0] e;
      arm = 1'b1; rd = 1'b1; @(negedge clk); arm = 1'b0; rd = 1'b0;
      raise(e);
      chk("R7 read beats arm", {31'h0, vld}, 32'h0);
      lower();
   endtask

   task automatic t_low_carry();
      logic [31:0] e;
      pulse_arm();
      while (ref_cnt != 32'h0000_FFFE) @(negedge clk);
      raise(e);
      chk("R4 low carry", stamp, 32'h0001_0000);
      pulse_rd();
      lower();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrap();
      t_closed();
      t_overrun();
      t_falling();
      t_interval();
      t_read_priority();
      t_low_carry();
      report();
   end
endmodule